// File: doc/BRIEF.md
# Hiccup-Mode Overcurrent Protection Sequencer

This block is the digital protection sequencer for one synchronous buck switching stage. A one-cycle `tick` marks each switching-period boundary. At that moment the block samples the valley current-limit flag `ilim`. It then gates the modulator's raw high-side request `pwm_req` into high-side and low-side gate enables.

A period that starts with the flag set is skipped: the high side stays off and the low side stays on. Overcurrent periods are counted cumulatively, and a short run of clean periods wipes the tally. When the tally reaches its limit, the stage is shut off for a fixed number of periods. It then comes back through a soft-start phase that ramps a maximum-duty limit for the modulator.

An over-temperature input forces the same all-off state for as long as it is high. When it falls, the stage restarts through soft-start. A status output shows the sequencer phase.

Top module: `hiccup_ocp_ctrl`

## Requirements
- R1: In the run phase (`state` = 0), `hs_en` equals `pwm_req` and `ls_en` equals its inverse. A tick with `ilim` low keeps the block in run.
- R2: A tick with `ilim` high, outside shutdown, moves the block to the skip phase (`state` = 1) for the following period. In skip, `hs_en` is 0 and `ls_en` is 1 whatever `pwm_req` is. A skip period that itself ends with `ilim` high stays in skip.
- R3: Every tick with `ilim` high adds one to an overcurrent tally. Overcurrent ticks need not be adjacent to be counted.
- R4: The tick that brings the tally to 8 moves the block to the shutdown phase (`state` = 2).
- R5: Three consecutive ticks with `ilim` low clear the tally to zero. Two clean ticks in a row do not clear it, and any overcurrent tick restarts the clean run.
- R6: In shutdown, `hs_en` and `ls_en` are both 0. The block stays in shutdown for 512 ticks.
- R7: On the 512th shutdown tick the block enters soft-start (`state` = 3) with `ss_en` = 1. In soft-start step k (k = 0..7), `duty_lim` is (k+1)*255/8, rounded down. Each clean tick advances k. The clean tick at k = 7 enters run, where `duty_lim` = 255 and `ss_en` = 0. In shutdown, `duty_lim` is 0.
- R8: Current-limit handling stays active in soft-start. An overcurrent tick there goes to skip without advancing k. The next clean tick returns to soft-start at the same k.
- R9: While `ot` is high, `hs_en` and `ls_en` are 0 in the same cycle, and the block enters shutdown at the next clock. In the first clock after `ot` falls, the block enters soft-start at k = 0.
- R10: A synchronous active-high `rst` holds `hs_en` and `ls_en` at 0. It places the block in soft-start at k = 0 with the overcurrent tally cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse at each switching-period boundary |
| ilim | input | 1 | Valley current-limit flag, sampled on `tick` |
| pwm_req | input | 1 | Raw high-side request from the modulator |
| ot | input | 1 | Over-temperature, active high |
| hs_en | output | 1 | Gated high-side enable |
| ls_en | output | 1 | Gated low-side enable |
| ss_en | output | 1 | Soft-start in progress |
| duty_lim | output | DUTY_W | Maximum-duty limit for the modulator |
| state | output | 2 | Phase: 0 run, 1 skip, 2 shutdown, 3 soft-start |

## Verification
The counting logic is driven with three patterns:
- Overcurrent ticks separated by two clean ticks. This shows that the tally accumulates across gaps and is not cleared early.
- A third clean tick followed by seven overcurrent ticks. This distinguishes a real clear from a tally that merely saturates.
- An eighth overcurrent tick, which must trigger shutdown.

The shutdown length is probed one tick short and exactly on the limit. The soft-start ramp is compared value by value, both with and without an overcurrent interruption. Over-temperature and reset are applied mid-run to confirm that the gates drop at once and that the restart takes the soft-start path.

// File: rtl/hiccup_ocp_ctrl.sv
module hiccup_ocp_ctrl #(
  parameter int OC_LIMIT       = 8,
  parameter int CLEAN_RUN      = 3,
  parameter int HICCUP_PERIODS = 512,
  parameter int SS_PERIODS     = 8,
  parameter int DUTY_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ilim,
  input  logic              pwm_req,
  input  logic              ot,
  output logic              hs_en,
  output logic              ls_en,
  output logic              ss_en,
  output logic [DUTY_W-1:0] duty_lim,
  output logic [1:0]        state
);

  localparam int OC_W = $clog2(OC_LIMIT + 1);
  localparam int CL_W = $clog2(CLEAN_RUN + 1);
  localparam int HT_W = $clog2(HICCUP_PERIODS + 1);
  localparam int SS_W = $clog2(SS_PERIODS + 1);
  localparam logic [OC_W-1:0] OC_MAX  = OC_W'(OC_LIMIT);
  localparam logic [CL_W-1:0] CL_MAX  = CL_W'(CLEAN_RUN);
  localparam logic [HT_W-1:0] HIC_END = HT_W'(HICCUP_PERIODS - 1);
  localparam logic [SS_W-1:0] SS_END  = SS_W'(SS_PERIODS);
  localparam int DMAX = (1 << DUTY_W) - 1;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SKIP   = 2'd1,
    ST_HICCUP = 2'd2,
    ST_SOFT   = 2'd3
  } st_t;

  st_t             st;
  logic            thermal;
  logic [OC_W-1:0] oc_cnt;
  logic [CL_W-1:0] clean_cnt;
  logic [HT_W-1:0] hic_cnt;
  logic [SS_W-1:0] ss_cnt;

  wire [OC_W-1:0] oc_inc    = oc_cnt + 1'b1;
  wire [CL_W-1:0] clean_inc = clean_cnt + 1'b1;
  wire            ss_done   = (ss_cnt == SS_END);
  wire            switching = (st == ST_RUN) || (st == ST_SOFT);
  wire            live      = !rst && !ot;
  wire [31:0]     ramp      = ((32'(ss_cnt) + 32'd1) * 32'(DMAX)) / 32'(SS_PERIODS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SOFT; thermal <= 1'b0;
      oc_cnt <= '0; clean_cnt <= '0; hic_cnt <= '0; ss_cnt <= '0;
    end else if (ot) begin
      st <= ST_HICCUP; thermal <= 1'b1;
      oc_cnt <= '0; clean_cnt <= '0; hic_cnt <= '0; ss_cnt <= '0;
    end else if (st == ST_HICCUP) begin
      if (thermal) begin
        st <= ST_SOFT; thermal <= 1'b0;
      end else if (tick) begin
        if (hic_cnt == HIC_END) begin
          st <= ST_SOFT; hic_cnt <= '0;
        end else begin
          hic_cnt <= hic_cnt + 1'b1;
        end
      end
    end else if (tick) begin
      if (ilim) begin
        clean_cnt <= '0;
        if (oc_inc == OC_MAX) begin
          st <= ST_HICCUP; oc_cnt <= '0; hic_cnt <= '0; ss_cnt <= '0;
        end else begin
          st <= ST_SKIP; oc_cnt <= oc_inc;
        end
      end else begin
        if (clean_inc == CL_MAX) begin
          clean_cnt <= '0; oc_cnt <= '0;
        end else begin
          clean_cnt <= clean_inc;
        end
        case (st)
          ST_SOFT: begin
            ss_cnt <= ss_cnt + 1'b1;
            if (ss_cnt == SS_END - 1'b1) st <= ST_RUN;
          end
          ST_SKIP: st <= ss_done ? ST_RUN : ST_SOFT;
          default: st <= ST_RUN;
        endcase
      end
    end
  end

  assign hs_en    = live && switching && pwm_req;
  assign ls_en    = live && ((st == ST_SKIP) || (switching && !pwm_req));
  assign ss_en    = !ot && (st != ST_HICCUP) && !ss_done;
  assign duty_lim = (st == ST_HICCUP) ? '0 : ss_done ? DUTY_W'(DMAX) : ramp[DUTY_W-1:0];
  assign state    = st;

  AST_SKIP_ON_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (tick && ilim && !ot && st != ST_HICCUP) |=> (st == ST_SKIP || st == ST_HICCUP)); // R2
  AST_TALLY_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    oc_cnt < OC_MAX); // R4
  AST_CLEAN_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tick && !ilim && !ot && st != ST_HICCUP && clean_cnt == CL_MAX - 1'b1) |=> oc_cnt == '0); // R5
  AST_HICCUP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HICCUP && !thermal && !tick && !ot) |=> st == ST_HICCUP); // R6
  AST_HICCUP_EXIT_SOFT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HICCUP && !ot) |=> (st == ST_HICCUP || st == ST_SOFT)); // R7
  AST_RESET_ENTRY: assert property (@(posedge clk)
    rst |=> (st == ST_SOFT && oc_cnt == '0 && clean_cnt == '0 && ss_cnt == '0)); // R10

endmodule

// File: tb/hiccup_ocp_ctrl_bench.sv
`timescale 1ns/1ps
module hiccup_ocp_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, ilim = 1'b0, pwm_req = 1'b0, ot = 1'b0;
  logic hs_en, ls_en, ss_en;
  logic [7:0] duty_lim;
  logic [1:0] state;
  int n_run = 0, n_fail = 0;

  localparam int S_RUN = 0, S_SKIP = 1, S_HIC = 2, S_SOFT = 3;

  always #2.5 clk = ~clk;

  hiccup_ocp_ctrl u_hiccup_ocp_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .ilim(ilim), .pwm_req(pwm_req), .ot(ot),
    .hs_en(hs_en), .ls_en(ls_en), .ss_en(ss_en), .duty_lim(duty_lim), .state(state));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic lim);
    @(negedge clk); tick = 1'b1; ilim = lim;
    @(negedge clk); tick = 1'b0; ilim = 1'b0;
  endtask

  function automatic int ramp(input int k);
    return ((k + 1) * 255) / 8;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pwm_req = 1'b1;
    #0.1;
    chk("R10 hs during reset", hs_en, 0);
    chk("R10 ls during reset", ls_en, 0);
    @(negedge clk); rst = 1'b0;
    chk("R10 state", state, S_SOFT);
    chk("R10 duty k0", duty_lim, ramp(0));
    chk("R10 ss_en", ss_en, 1);
  endtask

  task automatic t_soft_ramp();
    for (int k = 0; k < 8; k++) begin
      chk("R7 ramp", duty_lim, ramp(k));
      chk("R7 phase soft", state, S_SOFT);
      step(1'b0);
    end
    chk("R7 run after ramp", state, S_RUN);
    chk("R7 full duty", duty_lim, 255);
    chk("R7 ss_en off", ss_en, 0);
  endtask

  task automatic t_run();
    @(negedge clk); pwm_req = 1'b1; #0.1;
    chk("R1 hs follows", hs_en, 1); chk("R1 ls inverse", ls_en, 0);
    pwm_req = 1'b0; #0.1;
    chk("R1 hs follows low", hs_en, 0); chk("R1 ls inverse low", ls_en, 1);
    step(1'b0);
    chk("R1 stays run", state, S_RUN);
  endtask

  task automatic t_skip();
    step(1'b1);
    chk("R2 skip phase", state, S_SKIP);
    pwm_req = 1'b1; #0.1;
    chk("R2 hs off", hs_en, 0); chk("R2 ls on", ls_en, 1);
    step(1'b1);
    chk("R2 skip stretches", state, S_SKIP);
    chk("R2 ls held", ls_en, 1);
    for (int i = 0; i < 3; i++) step(1'b0);
    chk("R2 back to run", state, S_RUN);
    pwm_req = 1'b0;
  endtask

  task automatic t_count_and_hiccup();
    for (int i = 0; i < 7; i++) begin
      step(1'b1); step(1'b0); step(1'b0);
    end
    chk("R3 seven spread faults no shutdown", state, S_RUN);
    step(1'b0);
    for (int i = 0; i < 7; i++) step(1'b1);
    chk("R5 cleared tally, seven faults still skip", state, S_SKIP);
    step(1'b1);
    chk("R4 eighth fault shutdown", state, S_HIC);
    pwm_req = 1'b1; #0.1;
    chk("R6 hs off", hs_en, 0); chk("R6 ls off", ls_en, 0);
    chk("R7 duty zero in shutdown", duty_lim, 0);
    for (int i = 0; i < 511; i++) step(1'b1);
    chk("R6 still shut at 511", state, S_HIC);
    chk("R6 ls off at 511", ls_en, 0);
    step(1'b0);
    chk("R7 soft after 512", state, S_SOFT);
    chk("R7 ss_en", ss_en, 1);
    chk("R7 first ramp", duty_lim, ramp(0));
  endtask

  task automatic t_soft_with_fault();
    step(1'b0);
    chk("R8 k1", duty_lim, ramp(1));
    step(1'b1);
    chk("R8 skip in soft", state, S_SKIP);
    chk("R8 k held in skip", duty_lim, ramp(1));
    chk("R8 ss_en in skip", ss_en, 1);
    step(1'b0);
    chk("R8 back to soft", state, S_SOFT);
    chk("R8 same k", duty_lim, ramp(1));
    for (int i = 0; i < 7; i++) step(1'b0);
    chk("R8 ramp completes", state, S_RUN);
  endtask

  task automatic t_thermal();
    @(negedge clk); pwm_req = 1'b1; ot = 1'b1; #0.1;
    chk("R9 hs off at once", hs_en, 0); chk("R9 ls off at once", ls_en, 0);
    @(negedge clk);
    chk("R9 shutdown phase", state, S_HIC);
    step(1'b0); step(1'b0);
    chk("R9 held while hot", state, S_HIC);
    @(negedge clk); ot = 1'b0;
    @(negedge clk);
    chk("R9 soft after cool", state, S_SOFT);
    chk("R9 ramp start", duty_lim, ramp(0));
    chk("R9 hs resumes", hs_en, 1);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 8; i++) step(1'b0);
    chk("R10 pre run", state, S_RUN);
    do_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    t_soft_ramp();
    t_run();
    t_skip();
    t_count_and_hiccup();
    t_soft_with_fault();
    t_thermal();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule